// File: doc/BRIEF.md
# Bank-Interleaved Write Command Scheduler

This block takes write requests from a valid/ready interface and issues the command slots for a packet-based DRAM device. Each request carries one row address and two column addresses. The block produces four kinds of output: an activate on the row command channel, two column write commands on the column command channel, a mask slot paired with each column write, and a marker for each slot in which the device expects write data. One clock cycle is one packet slot.

Requests are spread over a fixed set of banks of a single device. The banks sit a stride of two apart, so neighbouring banks are never used back to back. This lets a new transaction start every row-to-row interval (T_RR) instead of once per full row cycle (T_RC). A bank is only used again after its row cycle has run out.

Rows are never closed by a separate precharge command. The second column write of each transaction carries the autoprecharge flag, and that closes the row. With a steady stream of requests, the column channel and the data slots are busy in every column-packet period.

Top module: `ilv_wr_sched`

## Requirements
- R1: During reset and in the first cycle after it, `row_vld`, `col_vld`, `msk_vld` and `dat_vld` are 0 and `req_ready` is 1.
- R2: After a request is accepted, `req_ready` stays 0 for T_RR-1 cycles, so accepts are at least T_RR cycles apart.
- R3: Accepted transactions go to banks in the order BASE_BANK, +STRIDE, +2·STRIDE, +3·STRIDE (modulo 2^BANK_W). The fifth transaction returns to BASE_BANK. The pointer moves only on an accept.
- R4: `req_ready` is 0 while the bank next in rotation has had an activate less than T_RC cycles earlier.
- R5: One cycle after an accept, `row_vld` is 1 for one cycle, with `row_bank` set to the rotation bank and `row_addr` set to the accepted row.
- R6: T_RCD cycles after the activate, a column write appears with `col_ap`=0, the same bank, and `col_addr` set to the first column address.
- R7: T_RR/2 cycles after the first column write, the second appears with `col_ap`=1 (autoprecharge), the same bank, and the second column address.
- R8: Each column write has a mask slot in the same cycle: `msk_vld`=1, `msk_bank` equal to the column bank, and `msk_sel` equal to 0 for the first write and 1 for the second.
- R9: T_CWD cycles after each column write, `dat_vld` is 1 for one cycle, with `dat_bank` set to that bank and `dat_sel` set to 0 or 1 to match the write.
- R10: `row_vld` rises only for accepted requests; no precharge or other row command is ever issued.
- R11: When requests arrive without gaps, column writes and data slots come out exactly every T_RR/2 cycles, with no holes.
- R12: A request presented while `req_ready` is 0 has no effect. Its fields may change freely, and only the values present in the accept cycle appear on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | ROW_W | Row address for the activate |
| req_col_a | input | COL_W | Column of the first (plain) write |
| req_col_b | input | COL_W | Column of the second (autoprecharge) write |
| row_vld | output | 1 | Activate slot strobe |
| row_bank | output | BANK_W | Bank of the activate |
| row_addr | output | ROW_W | Row of the activate |
| col_vld | output | 1 | Column write slot strobe |
| col_ap | output | 1 | 1 = write with autoprecharge |
| col_bank | output | BANK_W | Bank of the column write |
| col_addr | output | COL_W | Column of the write |
| msk_vld | output | 1 | Mask slot strobe |
| msk_sel | output | 1 | 0 = first write's mask, 1 = second |
| msk_bank | output | BANK_W | Bank of the masked write |
| dat_vld | output | 1 | Write data slot strobe |
| dat_sel | output | 1 | 0 = first dualoct, 1 = second |
| dat_bank | output | BANK_W | Bank receiving the data |

## Verification
The hardest case to reach is full-rate streaming across the rotation wrap. Here the bank timer of the returning bank must reach zero in exactly the same cycle as the issue-spacing counter, while the column and data slots of three or four transactions are in flight and interleaved. The bench reaches this by holding `req_valid` high for a long burst, so that every accept happens at the earliest legal cycle and the rotation wraps several times. A later phase uses pseudo-random gaps and changes the request fields while `req_ready` is low. A cycle-indexed model in the bench predicts every strobe and field.

// File: rtl/ilv_wr_pkg.sv
package ilv_wr_pkg;

  // Which of the two column writes (and data slots) of a transaction
  typedef enum logic {
    DS_FIRST  = 1'b0,
    DS_SECOND = 1'b1
  } dslot_e;

  // Width of a down-counter that must hold the value v
  function automatic int cnt_w(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ilv_wr_gap.sv
// Issue-spacing counter: after a start, blocks the next one for T_RR-1 cycles.
module ilv_wr_gap #(
  parameter int T_RR = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic free
);
  localparam int CW = ilv_wr_pkg::cnt_w(T_RR);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(T_RR - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign free = (cnt_q == '0);
endmodule

// File: rtl/ilv_wr_bank_timers.sv
// One row-cycle countdown per rotation slot, loaded on activate.
module ilv_wr_bank_timers #(
  parameter int NUM_ROT = 4,
  parameter int T_RC    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ROT-1:0] load,
  output logic [NUM_ROT-1:0] free
);
  localparam int CW = ilv_wr_pkg::cnt_w(T_RC);

  for (genvar i = 0; i < NUM_ROT; i++) begin : g_tmr
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else if (load[i]) begin
        cnt_q <= CW'(T_RC - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign free[i] = (cnt_q == '0);
  end
endmodule

// File: rtl/ilv_wr_pipe.sv
// Slot delay line; every stage is exposed as a tap (tap k = input delayed k+1 edges).
module ilv_wr_pipe #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [W-1:0]            din,
  output logic [DEPTH-1:0][W-1:0] taps
);
  logic [DEPTH-1:0][W-1:0] st_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_st
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[k] <= '0;
      end else if (k == 0) begin
        st_q[k] <= din;
      end else begin
        st_q[k] <= st_q[(k == 0) ? 0 : k - 1];
      end
    end
  end

  assign taps = st_q;
endmodule

// File: rtl/ilv_wr_sched.sv
module ilv_wr_sched #(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int NUM_ROT   = 4,
  parameter int STRIDE    = 2,
  parameter int BASE_BANK = 1,
  parameter int T_RR      = 4,
  parameter int T_RCD     = 7,
  parameter int T_CWD     = 6,
  parameter int T_RC      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col_a,
  input  logic [COL_W-1:0]  req_col_b,
  output logic              row_vld,
  output logic [BANK_W-1:0] row_bank,
  output logic [ROW_W-1:0]  row_addr,
  output logic              col_vld,
  output logic              col_ap,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              msk_vld,
  output logic              msk_sel,
  output logic [BANK_W-1:0] msk_bank,
  output logic              dat_vld,
  output logic              dat_sel,
  output logic [BANK_W-1:0] dat_bank
);
  import ilv_wr_pkg::*;

  localparam int T_CC   = T_RR / 2;                 // column packet period
  localparam int PIPE_D = T_RCD + T_CC + T_CWD;     // longest event offset
  localparam int ROT_W  = (NUM_ROT > 1) ? $clog2(NUM_ROT) : 1;
  localparam int PW     = 1 + BANK_W + 2 * COL_W;   // {vld, bank, col_a, col_b}
  localparam int P_CB   = 0;
  localparam int P_CA   = COL_W;
  localparam int P_BK   = 2 * COL_W;
  localparam int P_V    = 2 * COL_W + BANK_W;
  localparam int TAP_C1 = T_RCD - 1;
  localparam int TAP_C2 = T_RCD + T_CC - 1;
  localparam int TAP_D1 = T_RCD + T_CWD - 1;
  localparam int TAP_D2 = PIPE_D - 1;

  // Elaboration-time parameter checks
  if (T_RR < 2 || (T_RR % 2) != 0) begin : g_bad_rr
    $error("T_RR must be even and at least 2");
  end
  if (T_RC > 4 * T_RR) begin : g_bad_rc
    $error("T_RC must not exceed four T_RR intervals");
  end
  if (T_RCD < 1 || T_CWD < 1) begin : g_bad_lat
    $error("T_RCD and T_CWD must be at least 1");
  end

  // ---------------- issue control ----------------
  logic [ROT_W-1:0]   rot_q;
  logic [NUM_ROT-1:0] bank_free;
  logic [NUM_ROT-1:0] bank_load;
  logic               gap_free;
  logic               accept;
  logic [BANK_W-1:0]  cur_bank;

  assign req_ready = gap_free && bank_free[rot_q];
  assign accept    = req_valid && req_ready;
  assign cur_bank  = BANK_W'(BASE_BANK + STRIDE * int'(rot_q));

  always_comb begin
    bank_load = '0;
    if (accept) bank_load[rot_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q <= '0;
    end else if (accept) begin
      rot_q <= (rot_q == ROT_W'(NUM_ROT - 1)) ? '0 : rot_q + 1'b1;
    end
  end

  ilv_wr_gap #(.T_RR(T_RR)) u_gap (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .free  (gap_free)
  );

  ilv_wr_bank_timers #(.NUM_ROT(NUM_ROT), .T_RC(T_RC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (bank_load),
    .free (bank_free)
  );

  // ---------------- slot pipeline ----------------
  logic [PW-1:0]              pipe_in;
  logic [PIPE_D-1:0][PW-1:0]  taps;

  assign pipe_in = {accept, cur_bank, req_col_a, req_col_b};

  ilv_wr_pipe #(.DEPTH(PIPE_D), .W(PW)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .din  (pipe_in),
    .taps (taps)
  );

  logic [PW-1:0] t_c1, t_c2, t_d1, t_d2;
  assign t_c1 = taps[TAP_C1];
  assign t_c2 = taps[TAP_C2];
  assign t_d1 = taps[TAP_D1];
  assign t_d2 = taps[TAP_D2];

  // ---------------- row channel ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      row_vld  <= 1'b0;
      row_bank <= '0;
      row_addr <= '0;
    end else begin
      row_vld  <= accept;
      row_bank <= cur_bank;
      row_addr <= req_row;
    end
  end

  // ---------------- column and mask channels ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      col_vld  <= 1'b0;
      col_ap   <= 1'b0;
      col_bank <= '0;
      col_addr <= '0;
    end else if (t_c1[P_V]) begin
      col_vld  <= 1'b1;
      col_ap   <= 1'b0;
      col_bank <= t_c1[P_BK +: BANK_W];
      col_addr <= t_c1[P_CA +: COL_W];
    end else if (t_c2[P_V]) begin
      col_vld  <= 1'b1;
      col_ap   <= 1'b1;
      col_bank <= t_c2[P_BK +: BANK_W];
      col_addr <= t_c2[P_CB +: COL_W];
    end else begin
      col_vld  <= 1'b0;
      col_ap   <= 1'b0;
    end
  end

  dslot_e msk_sel_d, dat_sel_d;
  assign msk_sel_d = t_c1[P_V] ? DS_FIRST : DS_SECOND;
  assign dat_sel_d = t_d1[P_V] ? DS_FIRST : DS_SECOND;

  always_ff @(posedge clk) begin
    if (rst) begin
      msk_vld  <= 1'b0;
      msk_sel  <= 1'b0;
      msk_bank <= '0;
    end else begin
      msk_vld  <= t_c1[P_V] | t_c2[P_V];
      msk_sel  <= msk_sel_d;
      msk_bank <= t_c1[P_V] ? t_c1[P_BK +: BANK_W] : t_c2[P_BK +: BANK_W];
    end
  end

  // ---------------- data slot markers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_vld  <= 1'b0;
      dat_sel  <= 1'b0;
      dat_bank <= '0;
    end else begin
      dat_vld  <= t_d1[P_V] | t_d2[P_V];
      dat_sel  <= dat_sel_d;
      dat_bank <= t_d1[P_V] ? t_d1[P_BK +: BANK_W] : t_d2[P_BK +: BANK_W];
    end
  end

endmodule

// File: rtl/ilv_wr_sched_chk.sv
module ilv_wr_sched_chk #(
  parameter int BANK_W    = 3,
  parameter int NUM_ROT   = 4,
  parameter int STRIDE    = 2,
  parameter int BASE_BANK = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              row_vld,
  input logic [BANK_W-1:0] row_bank,
  input logic              col_vld,
  input logic              col_ap,
  input logic [BANK_W-1:0] col_bank,
  input logic              msk_vld,
  input logic              msk_sel,
  input logic [BANK_W-1:0] msk_bank
);
  localparam logic [BANK_W-1:0] FIRST_B = BANK_W'(BASE_BANK);
  localparam logic [BANK_W-1:0] LAST_B  = BANK_W'(BASE_BANK + STRIDE * (NUM_ROT - 1));

  logic              seen_row_q;
  logic [BANK_W-1:0] prev_bank_q;
  logic              plain_open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_row_q   <= 1'b0;
      prev_bank_q  <= '0;
      plain_open_q <= 1'b0;
    end else begin
      if (row_vld) begin
        seen_row_q  <= 1'b1;
        prev_bank_q <= row_bank;
      end
      if (col_vld) plain_open_q <= !col_ap;
    end
  end

  // R5: an accept is followed by an activate
  a_r5_row_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> row_vld);

  // R10: activates appear only for accepted requests
  a_r10_row_only_on_accept: assert property (@(posedge clk) disable iff (rst)
    row_vld |-> $past(req_valid && req_ready));

  // R2: ready drops right after an accept
  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R8: every column write carries its mask slot
  a_r8_mask_pairs: assert property (@(posedge clk) disable iff (rst)
    col_vld |-> (msk_vld && msk_bank == col_bank && msk_sel == col_ap));

  // R7: the autoprecharge write follows a plain write
  a_r7_ap_after_plain: assert property (@(posedge clk) disable iff (rst)
    (col_vld && col_ap) |-> plain_open_q);

  // R3: banks step by the stride and wrap to the base bank
  a_r3_bank_stride: assert property (@(posedge clk) disable iff (rst)
    (row_vld && seen_row_q) |->
      (row_bank == ((prev_bank_q == LAST_B) ? FIRST_B : BANK_W'(prev_bank_q + BANK_W'(STRIDE)))));
endmodule

bind ilv_wr_sched ilv_wr_sched_chk #(
  .BANK_W(BANK_W), .NUM_ROT(NUM_ROT), .STRIDE(STRIDE), .BASE_BANK(BASE_BANK)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .row_vld(row_vld), .row_bank(row_bank),
  .col_vld(col_vld), .col_ap(col_ap), .col_bank(col_bank),
  .msk_vld(msk_vld), .msk_sel(msk_sel), .msk_bank(msk_bank)
);

// File: tb/ilv_wr_sched_tb_top.sv
`timescale 1ns/1ps
module ilv_wr_sched_tb_top;
  localparam int BW = 3, RW = 8, CW = 6;
  localparam int NR = 4, STR = 2, BASE = 1;
  localparam int TRR = 4, TRCD = 7, TCWD = 6, TRC = 16;
  localparam int TCC = TRR / 2;
  localparam int RING = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic req_valid = 1'b0, req_ready;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col_a = '0, req_col_b = '0;
  logic row_vld, col_vld, col_ap, msk_vld, msk_sel, dat_vld, dat_sel;
  logic [BW-1:0] row_bank, col_bank, msk_bank, dat_bank;
  logic [RW-1:0] row_addr;
  logic [CW-1:0] col_addr;

  ilv_wr_sched #(
    .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .NUM_ROT(NR), .STRIDE(STR),
    .BASE_BANK(BASE), .T_RR(TRR), .T_RCD(TRCD), .T_CWD(TCWD), .T_RC(TRC)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col_a(req_col_a), .req_col_b(req_col_b),
    .row_vld(row_vld), .row_bank(row_bank), .row_addr(row_addr),
    .col_vld(col_vld), .col_ap(col_ap), .col_bank(col_bank), .col_addr(col_addr),
    .msk_vld(msk_vld), .msk_sel(msk_sel), .msk_bank(msk_bank),
    .dat_vld(dat_vld), .dat_sel(dat_sel), .dat_bank(dat_bank)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit            e_row_v [RING];
  int            e_row_b [RING];
  int            e_row_a [RING];
  bit            e_col_v [RING];
  bit            e_col_ap[RING];
  int            e_col_b [RING];
  int            e_col_a [RING];
  bit            e_dat_v [RING];
  bit            e_dat_s [RING];
  int            e_dat_b [RING];

  int  cyc = 0, m_ptr = 0, m_last = -1000, n_acc = 0, n_row = 0;
  int  m_act[NR];
  bit  mon_on = 1'b0;
  int  col_n = 0, col_first = -1, col_last = -1;
  int  dat_n = 0, dat_first = -1, dat_last = -1;

  initial for (int i = 0; i < NR; i++) m_act[i] = -1000;

  always @(negedge clk) begin
    if (mon_on) begin
      int s, b, k;
      bit exp_rdy;
      s = cyc % RING;
      // R2 R4: readiness from spacing and bank row cycle
      exp_rdy = ((cyc - m_last) >= TRR) && ((cyc - m_act[m_ptr]) >= TRC);
      chk(req_ready == exp_rdy, "R2 R4 ready", req_ready, exp_rdy);
      // R5 R10 R12 row channel
      if (e_row_v[s])
        chk(row_vld && row_bank == BW'(e_row_b[s]) && row_addr == RW'(e_row_a[s]),
            "R5 R3 R12 activate", {row_vld, row_bank, row_addr}, {1'b1, BW'(e_row_b[s]), RW'(e_row_a[s])});
      else
        chk(!row_vld, "R10 R12 no extra activate", row_vld, 0);
      // R6 R7 column channel, R8 mask
      if (e_col_v[s]) begin
        chk(col_vld && col_ap == e_col_ap[s] && col_bank == BW'(e_col_b[s]) && col_addr == CW'(e_col_a[s]),
            e_col_ap[s] ? "R7 second write" : "R6 first write",
            {col_vld, col_ap, col_bank, col_addr}, {1'b1, e_col_ap[s], BW'(e_col_b[s]), CW'(e_col_a[s])});
        chk(msk_vld && msk_sel == e_col_ap[s] && msk_bank == BW'(e_col_b[s]),
            "R8 mask", {msk_vld, msk_sel, msk_bank}, {1'b1, e_col_ap[s], BW'(e_col_b[s])});
      end else begin
        chk(!col_vld && !msk_vld, "R6 R7 R8 idle column", {col_vld, msk_vld}, 0);
      end
      // R9 data slots
      if (e_dat_v[s])
        chk(dat_vld && dat_sel == e_dat_s[s] && dat_bank == BW'(e_dat_b[s]),
            "R9 data slot", {dat_vld, dat_sel, dat_bank}, {1'b1, e_dat_s[s], BW'(e_dat_b[s])});
      else
        chk(!dat_vld, "R9 idle data", dat_vld, 0);
      if (row_vld) n_row++;
      if (col_vld) begin col_n++; if (col_first < 0) col_first = cyc; col_last = cyc; end
      if (dat_vld) begin dat_n++; if (dat_first < 0) dat_first = cyc; dat_last = cyc; end
      e_row_v[s] = 0; e_col_v[s] = 0; e_dat_v[s] = 0;
      // schedule the accepted transaction
      if (req_valid && exp_rdy) begin
        b = (BASE + STR * m_ptr) % (1 << BW);
        k = (cyc + 1) % RING;
        e_row_v[k] = 1; e_row_b[k] = b; e_row_a[k] = req_row;
        k = (cyc + 1 + TRCD) % RING;
        e_col_v[k] = 1; e_col_ap[k] = 0; e_col_b[k] = b; e_col_a[k] = req_col_a;
        k = (cyc + 1 + TRCD + TCC) % RING;
        e_col_v[k] = 1; e_col_ap[k] = 1; e_col_b[k] = b; e_col_a[k] = req_col_b;
        k = (cyc + 1 + TRCD + TCWD) % RING;
        e_dat_v[k] = 1; e_dat_s[k] = 0; e_dat_b[k] = b;
        k = (cyc + 1 + TRCD + TCC + TCWD) % RING;
        e_dat_v[k] = 1; e_dat_s[k] = 1; e_dat_b[k] = b;
        m_last = cyc; m_act[m_ptr] = cyc; m_ptr = (m_ptr + 1) % NR; n_acc++;
      end
      cyc++;
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] lfsr = 16'hACE1;
  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Present a request; fields are scrambled each cycle it is not accepted (R12)
  task automatic send(input int row, input int ca, input int cb);
    req_valid = 1'b1; req_row = RW'(row); req_col_a = CW'(ca); req_col_b = CW'(cb);
    forever begin
      @(negedge clk);
      if (req_ready) break;
      @(posedge clk); #1;
      step_lfsr();
      req_row = lfsr[RW-1:0]; req_col_a = lfsr[CW+3:4]; req_col_b = lfsr[15:16-CW];
    end
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < RING; i++) begin e_row_v[i] = 0; e_col_v[i] = 0; e_dat_v[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!row_vld && !col_vld && !msk_vld && !dat_vld, "R1 reset strobes",
        {row_vld, col_vld, msk_vld, dat_vld}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk(req_ready && !row_vld && !col_vld && !dat_vld, "R1 after reset",
        {req_ready, row_vld, col_vld, dat_vld}, 4'b1000);
    @(posedge clk); #1;

    // single isolated transaction
    send(8'h3C, 6'h11, 6'h2A);
    idle(30);

    // R11: full-rate burst of 16 with rotation wrapping
    col_n = 0; col_first = -1; dat_n = 0; dat_first = -1;
    for (int i = 0; i < 16; i++) send(i * 13 + 5, i + 1, 63 - i);
    idle(40);
    chk(col_n == 32, "R11 column count", col_n, 32);
    chk(col_last - col_first == 31 * TCC, "R11 column spacing", col_last - col_first, 31 * TCC);
    chk(dat_n == 32, "R11 data count", dat_n, 32);
    chk(dat_last - dat_first == 31 * TCC, "R11 data spacing", dat_last - dat_first, 31 * TCC);

    // random gaps, with changing fields while not ready (R12)
    for (int i = 0; i < 40; i++) begin
      step_lfsr();
      send(lfsr[7:0], lfsr[13:8], lfsr[5:0] ^ 6'h15);
      idle(int'(lfsr[10:8]));
    end
    idle(40);
    chk(n_row == n_acc, "R10 activates equal accepts", n_row, n_acc);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule